// File: doc/BRIEF.md
# Coherence Forwarded-Request Responder

This block is the snoop-side controller of one private cache in a MOESI-style protocol that supports migratory sharing. Forwarded coherence requests from other agents arrive on a valid/ready queue. Each request carries a request type and an address. Alongside the request, the surrounding cache presents three facts about the addressed line: whether its tag hits, whether its atomic-accessed bit is set, and its current stable or transient state.

The block first turns the request into an internal event. For a plain read this choice depends on the number of caches in the system and on a no-migrate option for atomically accessed lines. From the event and the line state it then chooses one of three outcomes:
- stall the queue;
- pop the request and issue a registered response, which gives a response kind, the resulting line state and a state-change flag;
- pop the request and pulse an error flag for a pairing that this block does not handle.

Back-pressure rules are as follows. `req_ready` is low only while the line is in a transient state. In that case the request stays at the head of the queue and produces nothing. A request is consumed on any edge where `req_valid` and `req_ready` are both high. The outcome for that request, either a response or an error, appears on the outputs for exactly the following cycle. The response side has no back-pressure.

Top module: `snp_fwd_responder`

## Requirements
- R1: After reset, and in any cycle with no request consumed on the previous edge, `rsp_valid` and `rsp_err` are 0.
- R2: With NUM_CACHES > 1, a GETS request (type 0) becomes the no-migrate read event when the tag hits, the atomic bit is set and NO_MIG_ATOMIC is 1. In every other case it becomes the ordinary other-read event.
- R3: With NUM_CACHES == 1, a GETS request becomes the DMA-only read event, whatever the tag-hit and atomic inputs are.
- R4: Type 1 (merged GETS) maps to the merged-read event. Type 2 (GETX) maps to other-write. Type 3 (INV) maps to invalidate.
- R5: Line states IT=12, ST=13, OT=14, MT=15 and MMT=16 hold `req_ready` at 0 for every event. No response and no error follow.
- R6: In I=0, IM=5, IS=8 and II=9, the events other-write, DMA read, other-read, no-migrate read and invalidate answer with ACK (kind 1) and leave the state unchanged.
- R7: In S=1 and SM=6, each of the three read events (DMA, other, no-migrate) answers with shared ACK (kind 2) and leaves the state unchanged.
- R8: In O=2 and OM=7, each of the three read events answers with shared data (kind 3) and leaves the state unchanged.
- R9: In MM=4, a DMA read answers with exclusive data (kind 4) and the state stays MM. A no-migrate read answers with shared data (kind 3) and the state becomes O (code 2).
- R10: In M=3, a DMA read answers with shared data (kind 3) and the state stays M. A merged read answers with shared data for multiple receivers (kind 5) and the state becomes O.
- R11: In OI=10 and MI=11, each of the three read events answers with data from the writeback buffer (kind 6) and the state becomes OI.
- R12: Any other pairing, including state codes 17 to 31, is still consumed (`req_ready`=1). It produces a one-cycle `rsp_err` pulse and no `rsp_valid`.
- R13: On the cycle after a response pairing is consumed, `rsp_valid` is 1 for that cycle only, together with the request's address. `rsp_next_state` gives the resulting state, and `rsp_state_chg` is 1 exactly when that state differs from the presented one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Forwarded request present at queue head |
| req_ready | output | 1 | Request consumed this edge (low means stall) |
| req_type | input | 2 | 0 GETS, 1 merged GETS, 2 GETX, 3 INV |
| req_addr | input | ADDR_W | Request address |
| line_tag_hit | input | 1 | Tag of the addressed line is present |
| line_atomic | input | 1 | Line's atomic-accessed bit |
| line_state | input | 5 | Current line state code |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_kind | output | 3 | 0 none, 1 ACK, 2 shared ACK, 3 shared data, 4 exclusive data, 5 shared data multi, 6 writeback data |
| rsp_addr | output | ADDR_W | Address of the answered request |
| rsp_next_state | output | 5 | Resulting line state |
| rsp_state_chg | output | 1 | Resulting state differs from presented state |
| rsp_err | output | 1 | One-cycle pulse for an unhandled pairing |

## Verification
The bench sweeps every request type against all 32 state codes and all four tag-hit/atomic combinations. It drives the same sweep into a multi-cache build with the no-migrate option on and into a single-cache build. The effect of the read classification is visible only through state behaviour. In MM, a no-migrate read moves the line to O, an ordinary other-read is an error, and a DMA read returns exclusive data. The MM rows therefore separate the three read events, and the M rows separate merged reads from DMA reads. An idle cycle after each request shows that the response is a single pulse. It also shows that stalled requests leave no trace.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    REQ_GETS  = 2'd0,
    REQ_MGETS = 2'd1,
    REQ_GETX  = 2'd2,
    REQ_INV   = 2'd3
  } req_e;

  typedef enum logic [2:0] {
    EV_OTHER_WR  = 3'd0,
    EV_DMA_RD    = 3'd1,
    EV_OTHER_RD  = 3'd2,
    EV_MERGED_RD = 3'd3,
    EV_NOMIG_RD  = 3'd4,
    EV_INVAL     = 3'd5
  } ev_e;

  typedef enum logic [4:0] {
    LS_I   = 5'd0,
    LS_S   = 5'd1,
    LS_O   = 5'd2,
    LS_M   = 5'd3,
    LS_MM  = 5'd4,
    LS_IM  = 5'd5,
    LS_SM  = 5'd6,
    LS_OM  = 5'd7,
    LS_IS  = 5'd8,
    LS_II  = 5'd9,
    LS_OI  = 5'd10,
    LS_MI  = 5'd11,
    LS_IT  = 5'd12,
    LS_ST  = 5'd13,
    LS_OT  = 5'd14,
    LS_MT  = 5'd15,
    LS_MMT = 5'd16
  } lstate_e;

  typedef enum logic [2:0] {
    RK_NONE       = 3'd0,
    RK_ACK        = 3'd1,
    RK_ACK_SHR    = 3'd2,
    RK_DATA_SHR   = 3'd3,
    RK_DATA_EXCL  = 3'd4,
    RK_DATA_MULTI = 3'd5,
    RK_DATA_WB    = 3'd6
  } rkind_e;

  typedef struct packed {
    logic         stall;
    logic         err;
    rkind_e       kind;
    logic [4:0]   nxt;
  } decision_t;

endpackage

// File: rtl/snp_classify.sv
module snp_classify
  import snp_pkg::*;
#(
  parameter int NUM_CACHES    = 2,
  parameter bit NO_MIG_ATOMIC = 1'b1
) (
  input  logic [1:0] req_type,
  input  logic       tag_hit,
  input  logic       atomic,
  output ev_e        ev
);
  localparam bit MULTI = (NUM_CACHES > 1);

  logic nomig_hit;
  ev_e  read_ev;

  assign nomig_hit = tag_hit && atomic && NO_MIG_ATOMIC;

  always_comb begin
    if (MULTI) read_ev = nomig_hit ? EV_NOMIG_RD : EV_OTHER_RD;
    else       read_ev = EV_DMA_RD;
  end

  always_comb begin
    unique case (req_e'(req_type))
      REQ_GETS:  ev = read_ev;
      REQ_MGETS: ev = EV_MERGED_RD;
      REQ_GETX:  ev = EV_OTHER_WR;
      default:   ev = EV_INVAL;
    endcase
  end
endmodule

// File: rtl/snp_decide.sv
module snp_decide
  import snp_pkg::*;
(
  input  ev_e         ev,
  input  logic [4:0]  cur,
  output decision_t   dec
);
  logic any_read;

  assign any_read = (ev == EV_DMA_RD) || (ev == EV_OTHER_RD) || (ev == EV_NOMIG_RD);

  always_comb begin
    dec.stall = 1'b0;
    dec.err   = 1'b0;
    dec.kind  = RK_NONE;
    dec.nxt   = cur;
    case (cur)
      LS_IT, LS_ST, LS_OT, LS_MT, LS_MMT: dec.stall = 1'b1;
      LS_I, LS_IM, LS_IS, LS_II: begin
        if (ev != EV_MERGED_RD) dec.kind = RK_ACK;
        else                    dec.err  = 1'b1;
      end
      LS_S, LS_SM: begin
        if (any_read) dec.kind = RK_ACK_SHR;
        else          dec.err  = 1'b1;
      end
      LS_O, LS_OM: begin
        if (any_read) dec.kind = RK_DATA_SHR;
        else          dec.err  = 1'b1;
      end
      LS_MM: begin
        if (ev == EV_DMA_RD) begin
          dec.kind = RK_DATA_EXCL;
        end else if (ev == EV_NOMIG_RD) begin
          dec.kind = RK_DATA_SHR;
          dec.nxt  = LS_O;
        end else begin
          dec.err = 1'b1;
        end
      end
      LS_M: begin
        if (ev == EV_DMA_RD) begin
          dec.kind = RK_DATA_SHR;
        end else if (ev == EV_MERGED_RD) begin
          dec.kind = RK_DATA_MULTI;
          dec.nxt  = LS_O;
        end else begin
          dec.err = 1'b1;
        end
      end
      LS_OI, LS_MI: begin
        if (any_read) begin
          dec.kind = RK_DATA_WB;
          dec.nxt  = LS_OI;
        end else begin
          dec.err = 1'b1;
        end
      end
      default: dec.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/snp_rsp_reg.sv
module snp_rsp_reg
  import snp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  decision_t         dec,
  input  logic [4:0]        cur,
  input  logic [ADDR_W-1:0] addr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [2:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [4:0]        rsp_next_state,
  output logic              rsp_state_chg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_err        <= 1'b0;
      rsp_kind       <= RK_NONE;
      rsp_addr       <= '0;
      rsp_next_state <= '0;
      rsp_state_chg  <= 1'b0;
    end else begin
      rsp_valid <= accept && !dec.err;
      rsp_err   <= accept && dec.err;
      if (accept) begin
        rsp_kind       <= dec.err ? RK_NONE : dec.kind;
        rsp_addr       <= addr;
        rsp_next_state <= dec.nxt;
        rsp_state_chg  <= !dec.err && (dec.nxt != cur);
      end
    end
  end
endmodule

// File: rtl/snp_fwd_responder.sv
module snp_fwd_responder
  import snp_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int NUM_CACHES    = 2,
  parameter bit NO_MIG_ATOMIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              line_tag_hit,
  input  logic              line_atomic,
  input  logic [4:0]        line_state,
  output logic              rsp_valid,
  output logic [2:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [4:0]        rsp_next_state,
  output logic              rsp_state_chg,
  output logic              rsp_err
);
  ev_e       ev;
  decision_t dec;
  logic      accept;

  snp_classify #(
    .NUM_CACHES   (NUM_CACHES),
    .NO_MIG_ATOMIC(NO_MIG_ATOMIC)
  ) u_classify (
    .req_type(req_type),
    .tag_hit (line_tag_hit),
    .atomic  (line_atomic),
    .ev      (ev)
  );

  snp_decide u_decide (
    .ev (ev),
    .cur(line_state),
    .dec(dec)
  );

  assign req_ready = !dec.stall;
  assign accept    = req_valid && req_ready;

  snp_rsp_reg #(.ADDR_W(ADDR_W)) u_rsp (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .dec           (dec),
    .cur           (line_state),
    .addr          (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_kind      (rsp_kind),
    .rsp_addr      (rsp_addr),
    .rsp_next_state(rsp_next_state),
    .rsp_state_chg (rsp_state_chg)
  );
endmodule

// File: rtl/snp_fwd_responder_chk.sv
module snp_fwd_responder_chk
  import snp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_type,
  input logic [ADDR_W-1:0] req_addr,
  input logic              line_tag_hit,
  input logic              line_atomic,
  input logic [4:0]        line_state,
  input logic              rsp_valid,
  input logic [2:0]        rsp_kind,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [4:0]        rsp_next_state,
  input logic              rsp_state_chg,
  input logic              rsp_err
);
  logic transient;
  assign transient = (line_state >= 5'd12) && (line_state <= 5'd16);

  AST_TRANSIENT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    transient |-> !req_ready) else $error("stall"); // R5

  AST_STABLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !transient |-> req_ready) else $error("ready"); // R12

  AST_POP_GIVES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid ^ rsp_err)) else $error("outcome"); // R13

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (!rsp_valid && !rsp_err)) else $error("idle"); // R1

  AST_RSP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_addr == $past(req_addr))) else $error("addr"); // R13

  AST_EXCL_ONLY_MM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) ##1 (rsp_valid && rsp_kind == RK_DATA_EXCL)
      |-> $past(line_state) == LS_MM) else $error("excl"); // R9

  AST_CHG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_state_chg) |-> (rsp_next_state == LS_O || rsp_next_state == LS_OI))
    else $error("chg"); // R11

  AST_ERR_NO_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_kind == RK_NONE) else $error("errkind"); // R12
endmodule

bind snp_fwd_responder snp_fwd_responder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/snp_fwd_responder_bench.sv
`timescale 1ns/1ps
module snp_fwd_responder_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_type = '0;
  logic [AW-1:0] req_addr = '0;
  logic          hit = 1'b0, atom = 1'b0;
  logic [4:0]    lstate = '0;

  logic          rdy_m, vld_m, chg_m, err_m;
  logic [2:0]    kind_m;
  logic [AW-1:0] addr_m;
  logic [4:0]    nxt_m;
  logic          rdy_s, vld_s, chg_s, err_s;
  logic [2:0]    kind_s;
  logic [AW-1:0] addr_s;
  logic [4:0]    nxt_s;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  snp_fwd_responder #(.ADDR_W(AW), .NUM_CACHES(2), .NO_MIG_ATOMIC(1'b1)) u_snp_fwd_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_m),
    .req_type(req_type), .req_addr(req_addr), .line_tag_hit(hit), .line_atomic(atom),
    .line_state(lstate), .rsp_valid(vld_m), .rsp_kind(kind_m), .rsp_addr(addr_m),
    .rsp_next_state(nxt_m), .rsp_state_chg(chg_m), .rsp_err(err_m));

  snp_fwd_responder #(.ADDR_W(AW), .NUM_CACHES(1), .NO_MIG_ATOMIC(1'b1)) u_snp_fwd_responder_solo (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_s),
    .req_type(req_type), .req_addr(req_addr), .line_tag_hit(hit), .line_atomic(atom),
    .line_state(lstate), .rsp_valid(vld_s), .rsp_kind(kind_s), .rsp_addr(addr_s),
    .rsp_next_state(nxt_s), .rsp_state_chg(chg_s), .rsp_err(err_s));

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Independent expectation: event code, then outcome per state group.
  task automatic model(input int nc, input int t, input int s, input bit h, input bit a,
                       output bit stall, output bit err, output int kind, output int nxt,
                       output string tag);
    int  ev;
    bit  rd;
    string grp;
    string cls;
    if (t == 1)      begin ev = 3; cls = "R4"; end
    else if (t == 2) begin ev = 0; cls = "R4"; end
    else if (t == 3) begin ev = 5; cls = "R4"; end
    else if (nc > 1) begin ev = (h && a) ? 4 : 2; cls = "R2"; end
    else             begin ev = 1; cls = "R3"; end
    rd = (ev == 1) || (ev == 2) || (ev == 4);
    stall = 1'b0; err = 1'b0; kind = 0; nxt = s;
    if (s >= 12 && s <= 16) begin
      stall = 1'b1; grp = "R5";
    end else if (s == 0 || s == 5 || s == 8 || s == 9) begin
      grp = "R6"; if (ev != 3) kind = 1; else err = 1'b1;
    end else if (s == 1 || s == 6) begin
      grp = "R7"; if (rd) kind = 2; else err = 1'b1;
    end else if (s == 2 || s == 7) begin
      grp = "R8"; if (rd) kind = 3; else err = 1'b1;
    end else if (s == 4) begin
      grp = "R9";
      if (ev == 1) kind = 4;
      else if (ev == 4) begin kind = 3; nxt = 2; end
      else err = 1'b1;
    end else if (s == 3) begin
      grp = "R10";
      if (ev == 1) kind = 3;
      else if (ev == 3) begin kind = 5; nxt = 2; end
      else err = 1'b1;
    end else if (s == 10 || s == 11) begin
      grp = "R11"; if (rd) begin kind = 6; nxt = 10; end else err = 1'b1;
    end else begin
      grp = "R12"; err = 1'b1;
    end
    if (err) grp = "R12";
    tag = {grp, "/", cls};
  endtask

  task automatic check_one(input int nc, input int t, input int s, input bit h, input bit a,
                           input logic [AW-1:0] ad,
                           input logic vld, input logic er, input logic [2:0] kd,
                           input logic [AW-1:0] ra, input logic [4:0] nx, input logic cg);
    bit stall, err;
    int kind, nxt;
    string tag;
    model(nc, t, s, h, a, stall, err, kind, nxt, tag);
    check(tag, "rsp_valid", int'(vld), int'(!stall && !err));
    check(tag, "rsp_err", int'(er), int'(!stall && err));
    if (!stall && !err) begin
      check(tag, "rsp_kind", int'(kd), kind);
      check(tag, "rsp_next_state", int'(nx), nxt);
      check("R13", "rsp_state_chg", int'(cg), int'(nxt != s));
      check("R13", "rsp_addr", int'(ra), int'(ad));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid after reset", int'(vld_m | vld_s), 0);
    check("R1", "rsp_err after reset", int'(err_m | err_s), 0);

    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 32; s++) begin
        for (int hv = 0; hv < 2; hv++) begin
          for (int av = 0; av < 2; av++) begin
            logic [AW-1:0] ad;
            bit tr;
            ad = AW'((t * 4099) ^ (s * 263) ^ (hv * 37) ^ (av * 11) ^ 16'h5a00);
            tr = (s >= 12 && s <= 16);
            req_valid = 1'b1;
            req_type  = 2'(t);
            lstate    = 5'(s);
            hit       = hv[0];
            atom      = av[0];
            req_addr  = ad;
            #1;
            check(tr ? "R5" : "R12", "req_ready multi", int'(rdy_m), int'(!tr));
            check(tr ? "R5" : "R12", "req_ready solo", int'(rdy_s), int'(!tr));
            @(posedge clk);
            #2;
            check_one(2, t, s, hv[0], av[0], ad, vld_m, err_m, kind_m, addr_m, nxt_m, chg_m);
            check_one(1, t, s, hv[0], av[0], ad, vld_s, err_s, kind_s, addr_s, nxt_s, chg_s);
            @(negedge clk);
            req_valid = 1'b0;
            @(posedge clk);
            #2;
            check("R13", "pulse drop", int'(vld_m | vld_s | err_m | err_s), 0);
            @(negedge clk);
          end
        end
      end
    end
    finish_run();
  end
endmodule